// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port with a small register bus. Software sets each pin's direction, output data, digital-input enable, peripheral hand-over, pull resistors and open-drain mode. It also sets how each pin raises an interrupt. Every port in a system is one more copy of this block. The pad itself appears as four per-pin controls: output enable, output value, pull-up request and pull-down request. A peripheral that takes over a pin appears as an output/enable pair going in and a synchronised input coming out.

The data register has a bit mask in the word address of each access. A write changes only the pins whose mask bit is set, so no read-modify-write is needed. A read returns zero on the pins that are not selected. Pin inputs pass through a two-flop synchroniser. Edge or level detection then runs on the synchronised value. A raw status, a masked status and one combined interrupt line report the result. Pins in a parameterised debug set come out of reset already handed to their peripheral, with the input enabled and the pull-up on.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Reset sets the configuration to defaults. Pins outside DBG_PINS (default 8'h0F) have direction, data, peripheral select, pull-up, pull-down, open-drain and input enable all cleared, so they are tri-stated. Pins in DBG_PINS have peripheral select (0x420), pull-up (0x424) and input enable (0x430) set.
- R2: Either `por_rst` or `ext_rst` high at a clock edge brings back every reset default of R1.
- R3: A write to word address {00, m[7:0]} (byte address bits [9:2] = m, bits [11:10] = 0) updates data bit n only where m[n] = 1.
- R4: A read of the data region returns zero in every bit where m[n] = 0. Where m[n] = 1 it returns the data bit for an output pin (direction register 0x400 bit = 1) or the synchronised input for an input pin.
- R5: With peripheral select and open-drain clear, `pad_oe` equals the direction bit and `pad_out` equals the data bit.
- R6: With open-drain (0x42C) set and peripheral select clear, `pad_out` is 0 and `pad_oe` is set only when the direction bit is 1 and the data bit is 0.
- R7: With peripheral select set, `pad_oe` and `pad_out` follow `alt_oe` and `alt_out`. `alt_in` carries the synchronised, input-enable-gated pin value.
- R8: `pad_pu` and `pad_pd` reflect the pull-up (0x424) and pull-down (0x428) registers.
- R9: In edge mode (level-select 0x404 bit = 0), a pin latches raw status (0x414) on a rising edge when polarity (0x40C) is 1, on a falling edge when it is 0, and on either edge when both-edges (0x408) is 1.
- R10: In level mode, raw status follows the synchronised input: it is 1 while the input is high (polarity 1) or low (polarity 0). A clear has no effect on it.
- R11: Writing 1 to a bit of the clear register (0x41C) resets that latched edge status. A latched bit stays set until cleared. A new edge that lands in the same cycle as its clear wins.
- R12: Masked status (0x418) is raw status ANDed with the interrupt mask (0x410). `irq` is high when any masked status bit is high.
- R13: A pin whose input enable is 0 reads as 0 and has raw status 0.
- R14: A pin change driven before clock edge k appears in a data read after edge k+1, and in latched edge status after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | External reset, synchronous, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pad_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Value driven onto each pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_pu | output | 8 | Pull-up request per pin |
| pad_pd | output | 8 | Pull-down request per pin |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| alt_in | output | 8 | Synchronised pin value to the peripheral |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a clear write that arrives in the same cycle as a new edge on the same pin. The clear must lose, so the status must survive. The stimulus first sets the status with one rising edge and drops the pin. It then raises the pin again and counts two clock edges through the synchroniser. The clear write is placed so that it commits on exactly the third edge, where the new event latches. A second, ordinary clear afterwards confirms that the bit really was live.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int NPIN = 8;
    localparam int AW   = 12;

    typedef enum logic [3:0] {
        CR_DIR   = 4'd0,
        CR_LVL   = 4'd1,
        CR_BOTH  = 4'd2,
        CR_POL   = 4'd3,
        CR_MASK  = 4'd4,
        CR_RAW   = 4'd5,
        CR_MSTAT = 4'd6,
        CR_CLR   = 4'd7,
        CR_ALT   = 4'd8,
        CR_PU    = 4'd9,
        CR_PD    = 4'd10,
        CR_OD    = 4'd11,
        CR_DEN   = 4'd12
    } cfg_reg_e;

    typedef struct packed {
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] both;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] msk;
        logic [NPIN-1:0] alt;
        logic [NPIN-1:0] pu;
        logic [NPIN-1:0] pd;
        logic [NPIN-1:0] od;
        logic [NPIN-1:0] den;
    } port_cfg_t;

    function automatic logic is_data_hit(logic [AW-1:0] a);
        return (a[AW-1:AW-2] == 2'b00) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic is_cfg_hit(logic [AW-1:0] a);
        return (a[AW-1:AW-2] == 2'b01) && (a[AW-3:6] == '0) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [NPIN-1:0] addr_mask(logic [AW-1:0] a);
        return a[NPIN+1:2];
    endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
    input  logic clk,
    input  logic rst,
    input  logic s,
    input  logic den,
    input  logic lvl,
    input  logic both,
    input  logic pol,
    input  logic clr,
    output logic raw
);
    logic s_d;
    logic latch_q;
    logic rise, fall, ev, lvl_hit;

    always_comb begin
        rise    = s & ~s_d;
        fall    = ~s & s_d;
        ev      = den & ~lvl & (both ? (rise | fall) : (pol ? rise : fall));
        lvl_hit = pol ? s : ~s;
        raw     = den & (lvl ? lvl_hit : latch_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_d     <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            s_d <= s;
            if (lvl) latch_q <= 1'b0;
            else     latch_q <= (latch_q & ~clr) | ev;
        end
    end
endmodule

// File: rtl/gpio_pad_pin.sv
module gpio_pad_pin (
    input  logic alt,
    input  logic od,
    input  logic dir,
    input  logic dout,
    input  logic alt_o,
    input  logic alt_e,
    output logic o,
    output logic e
);
    always_comb begin
        if (alt) begin
            o = alt_o;
            e = alt_e;
        end else if (od) begin
            o = 1'b0;
            e = dir & ~dout;
        end else begin
            o = dout;
            e = dir;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter logic [NPIN-1:0] DBG_PINS = 8'h0F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] s_in,
    input  logic [NPIN-1:0] ris,
    output port_cfg_t       cfg,
    output logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] rdata
);
    logic            dhit, chit;
    logic [NPIN-1:0] m;
    cfg_reg_e        sel;
    logic [NPIN-1:0] pin_view;

    always_comb begin
        dhit     = is_data_hit(addr);
        chit     = is_cfg_hit(addr);
        m        = addr_mask(addr);
        sel      = cfg_reg_e'(addr[5:2]);
        pin_view = (cfg.dir & cfg.dout) | (~cfg.dir & s_in);
        clr      = (wr && chit && sel == CR_CLR) ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.dir  <= '0;
            cfg.dout <= '0;
            cfg.lvl  <= '0;
            cfg.both <= '0;
            cfg.pol  <= '0;
            cfg.msk  <= '0;
            cfg.pd   <= '0;
            cfg.od   <= '0;
            cfg.alt  <= DBG_PINS;
            cfg.pu   <= DBG_PINS;
            cfg.den  <= DBG_PINS;
        end else if (wr) begin
            if (dhit) begin
                cfg.dout <= (cfg.dout & ~m) | (wdata & m);
            end else if (chit) begin
                case (sel)
                    CR_DIR:  cfg.dir  <= wdata;
                    CR_LVL:  cfg.lvl  <= wdata;
                    CR_BOTH: cfg.both <= wdata;
                    CR_POL:  cfg.pol  <= wdata;
                    CR_MASK: cfg.msk  <= wdata;
                    CR_ALT:  cfg.alt  <= wdata;
                    CR_PU:   cfg.pu   <= wdata;
                    CR_PD:   cfg.pd   <= wdata;
                    CR_OD:   cfg.od   <= wdata;
                    CR_DEN:  cfg.den  <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (dhit) begin
            rdata = pin_view & m;
        end else if (chit) begin
            case (sel)
                CR_DIR:   rdata = cfg.dir;
                CR_LVL:   rdata = cfg.lvl;
                CR_BOTH:  rdata = cfg.both;
                CR_POL:   rdata = cfg.pol;
                CR_MASK:  rdata = cfg.msk;
                CR_RAW:   rdata = ris;
                CR_MSTAT: rdata = ris & cfg.msk;
                CR_ALT:   rdata = cfg.alt;
                CR_PU:    rdata = cfg.pu;
                CR_PD:    rdata = cfg.pd;
                CR_OD:    rdata = cfg.od;
                CR_DEN:   rdata = cfg.den;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter logic [NPIN-1:0] DBG_PINS = 8'h0F
) (
    input  logic            clk,
    input  logic            por_rst,
    input  logic            ext_rst,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] alt_in,
    output logic            irq
);
    logic            rst_any;
    logic [NPIN-1:0] s_raw, s_in, ris, clr;
    port_cfg_t       cfg;

    assign rst_any = por_rst | ext_rst;

    gpio_sync2 #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst_any),
        .d   (pad_in),
        .q   (s_raw)
    );

    assign s_in   = s_raw & cfg.den;
    assign alt_in = s_in;

    gpio_port_regs #(.DBG_PINS(DBG_PINS)) u_regs (
        .clk   (clk),
        .rst   (rst_any),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .s_in  (s_in),
        .ris   (ris),
        .cfg   (cfg),
        .clr   (clr),
        .rdata (bus_rdata)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_irq_pin u_irq (
            .clk  (clk),
            .rst  (rst_any),
            .s    (s_in[i]),
            .den  (cfg.den[i]),
            .lvl  (cfg.lvl[i]),
            .both (cfg.both[i]),
            .pol  (cfg.pol[i]),
            .clr  (clr[i]),
            .raw  (ris[i])
        );
        gpio_pad_pin u_pad (
            .alt   (cfg.alt[i]),
            .od    (cfg.od[i]),
            .dir   (cfg.dir[i]),
            .dout  (cfg.dout[i]),
            .alt_o (alt_out[i]),
            .alt_e (alt_oe[i]),
            .o     (pad_out[i]),
            .e     (pad_oe[i])
        );
    end

    assign pad_pu = cfg.pu;
    assign pad_pd = cfg.pd;
    assign irq    = |(ris & cfg.msk);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter logic [NPIN-1:0] DBG_PINS = 8'h0F
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NPIN-1:0] bus_rdata,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] ris,
    input logic            irq,
    input port_cfg_t       cfg
);
    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        $past(rst) |-> (cfg.alt == DBG_PINS && cfg.pu == DBG_PINS && cfg.den == DBG_PINS
                        && cfg.dir == '0 && cfg.pd == '0 && cfg.od == '0)); // R1

    AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[AW-1:AW-2] == 2'b00) |-> ((bus_rdata & ~bus_addr[NPIN+1:2]) == '0)); // R4

    AST_INPUT_TRISTATE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~cfg.alt & ~cfg.dir) == '0)); // R5

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_out & cfg.od & ~cfg.alt) == '0)); // R6

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ((ris & $past(ris) & ~cfg.lvl) == ($past(ris) & ~cfg.lvl))); // R11

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cfg.msk != '0)); // R12
endmodule

bind gpio_port_ctrl gpio_port_chk #(.DBG_PINS(DBG_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst_any),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .ris       (ris),
    .irq       (irq),
    .cfg       (cfg)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    localparam logic [11:0] A_DIR = 12'h400, A_LVL = 12'h404, A_BOTH = 12'h408,
                            A_POL = 12'h40C, A_MASK = 12'h410, A_RAW = 12'h414,
                            A_MST = 12'h418, A_CLR = 12'h41C, A_ALT = 12'h420,
                            A_PU = 12'h424, A_PD = 12'h428, A_OD = 12'h42C,
                            A_DEN = 12'h430;

    logic       clk = 1'b0;
    logic       por_rst = 1'b1, ext_rst = 1'b0;
    logic       bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;
    logic [7:0] alt_out = '0, alt_oe = '0, alt_in;
    logic       irq;
    int         tests = 0, fails = 0;

    always #5 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .por_rst(por_rst), .ext_rst(ext_rst), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in),
        .irq(irq)
    );

    function automatic logic [11:0] dadr(logic [7:0] m);
        return {2'b00, m, 2'b00};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [11:0] a, logic [7:0] exp);
        bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic t_reset;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h0F);
        check("R1 pad_pd", pad_pd, 8'h00);
        rd_chk("R1 alt", A_ALT, 8'h0F);
        rd_chk("R1 den", A_DEN, 8'h0F);
        rd_chk("R1 dir", A_DIR, 8'h00);
    endtask

    task automatic t_ext_reset;
        wr(A_ALT, 8'h00); wr(A_PU, 8'hF0); wr(A_DIR, 8'hFF);
        ext_rst = 1'b1; ticks(1); ext_rst = 1'b0;
        rd_chk("R2 alt", A_ALT, 8'h0F);
        rd_chk("R2 dir", A_DIR, 8'h00);
        check("R2 pad_pu", pad_pu, 8'h0F);
    endtask

    task automatic t_data_masking;
        wr(A_ALT, 8'h00); wr(A_DIR, 8'hFF);
        wr(dadr(8'hFF), 8'hFF);
        check("R5 oe", pad_oe, 8'hFF);
        check("R5 out", pad_out, 8'hFF);
        wr(dadr(8'h0F), 8'h00);
        check("R3 masked write", pad_out, 8'hF0);
        wr(dadr(8'h81), 8'hFF);
        check("R3 masked set", pad_out, 8'hF1);
        rd_chk("R4 read sel", dadr(8'h30), 8'h30);
        rd_chk("R4 read unsel", dadr(8'h0E), 8'h00);
        wr(A_DIR, 8'h0F);
        check("R5 input tri", pad_oe, 8'h0F);
    endtask

    task automatic t_open_drain;
        wr(A_DIR, 8'h03); wr(dadr(8'h03), 8'h02); wr(A_OD, 8'h03);
        check("R6 oe", pad_oe & 8'h03, 8'h01);
        check("R6 out", pad_out & 8'h03, 8'h00);
        wr(A_OD, 8'h00);
    endtask

    task automatic t_alt_and_pulls;
        wr(A_DEN, 8'hFF);
        pad_in = 8'h04;
        wr(A_ALT, 8'h06); alt_out = 8'h02; alt_oe = 8'h06;
        ticks(2);
        check("R7 alt oe", pad_oe & 8'h06, 8'h06);
        check("R7 alt out", pad_out & 8'h06, 8'h02);
        check("R7 alt_in", alt_in, 8'h04);
        wr(A_ALT, 8'h00); alt_oe = 8'h00; pad_in = 8'h00;
        wr(A_PU, 8'h5A); wr(A_PD, 8'hA5);
        check("R8 pu", pad_pu, 8'h5A);
        check("R8 pd", pad_pd, 8'hA5);
    endtask

    task automatic t_latency;
        wr(A_DIR, 8'h00);
        pad_in = 8'h40;
        ticks(1);
        rd_chk("R14 after 1 edge", dadr(8'h40), 8'h00);
        ticks(1);
        rd_chk("R14 after 2 edges", dadr(8'h40), 8'h40);
        pad_in = 8'h00; ticks(3);
    endtask

    task automatic t_edges;
        wr(A_LVL, 8'h00); wr(A_BOTH, 8'h04); wr(A_POL, 8'h01);
        ticks(3); wr(A_CLR, 8'hFF);
        rd_chk("R11 cleared", A_RAW, 8'h00);
        pad_in = 8'h07;
        ticks(2);
        rd_chk("R14 edge not yet", A_RAW, 8'h00);
        ticks(1);
        rd_chk("R9 rise/both", A_RAW, 8'h05);
        wr(A_CLR, 8'hFF);
        pad_in = 8'h00;
        ticks(4);
        rd_chk("R9 fall/both", A_RAW, 8'h06);
        wr(A_CLR, 8'hFF);
    endtask

    task automatic t_clear_race;
        pad_in = 8'h01; ticks(4);
        rd_chk("R11 set", A_RAW & 12'hFFF, 8'h01);
        ticks(4);
        rd_chk("R11 sticky", A_RAW, 8'h01);
        pad_in = 8'h00; ticks(4);
        pad_in = 8'h01;
        ticks(2);
        wr(A_CLR, 8'h01);
        rd_chk("R11 event beats clear", A_RAW, 8'h01);
        wr(A_CLR, 8'h01);
        rd_chk("R11 plain clear", A_RAW, 8'h00);
        pad_in = 8'h00; ticks(4); wr(A_CLR, 8'hFF);
    endtask

    task automatic t_level_irq;
        wr(A_LVL, 8'h30); wr(A_POL, 8'h10);
        ticks(1);
        rd_chk("R10 low level", A_RAW, 8'h20);
        pad_in = 8'h30; ticks(2);
        rd_chk("R10 high level", A_RAW, 8'h10);
        wr(A_CLR, 8'h30);
        rd_chk("R10 clear no effect", A_RAW, 8'h10);
        wr(A_MASK, 8'h10);
        rd_chk("R12 masked status", A_MST, 8'h10);
        check("R12 irq on", {7'd0, irq}, 8'h01);
        wr(A_MASK, 8'h20);
        check("R12 irq off", {7'd0, irq}, 8'h00);
        wr(A_MASK, 8'h10);
        wr(A_DEN, 8'hEF);
        rd_chk("R13 raw off", A_RAW, 8'h00);
        check("R13 no irq", {7'd0, irq}, 8'h00);
        rd_chk("R13 reads zero", dadr(8'h30), 8'h20);
    endtask

    initial begin
        ticks(3);
        por_rst = 1'b0;
        ticks(1);
        t_reset();
        t_ext_reset();
        t_data_masking();
        t_open_drain();
        t_alt_and_pulls();
        t_latency();
        t_edges();
        t_clear_race();
        t_level_irq();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule